// File: doc/BRIEF.md
# Routable Interrupt Collector with Per-Source Steering

This block gathers up to 32 interrupt request inputs and turns them into a grid of parent interrupt lines, one set of lines per core. Software sets, for each source, whether it is level or edge sensitive and which polarity or edge direction counts as active. It also sets whether the source is enabled. Each source also has a steering byte that names which cores and which parent lines the source drives. A core's handler can then read one status word to learn which enabled sources are active.

All inputs are treated as asynchronous. They pass through a flop synchronizer before any decision is made. In edge mode a detected edge is held in a sticky latch until software disables the source. Enables are never written directly. One word address turns enables on, another turns them off, and a third reads the result. Every parent output is a flop.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset, the enable mask (0x24), polarity (0x30), edge select (0x34), pending status (0x40) and every steering byte read zero, and all outputs are low.
- R2: Writing to byte offset i (0x00 to 0x1F) stores bus_wdata[7:0] as the steering byte of source i. Reading that offset returns the byte zero-extended to 32 bits.
- R3: A read of offset 0x24 returns the current enable mask, with bit i belonging to source i.
- R4: A write to offset 0x28 turns on the enable of each source whose data bit is 1 and leaves the other enables unchanged.
- R5: A write to offset 0x2C turns off the enable of each source whose data bit is 1. Writing all ones turns off every source.
- R6: With edge select bit i at 0 (level mode), polarity bit 1 makes source i active while its input is high, and polarity bit 0 makes it active while its input is low. The pending bit follows the input.
- R7: With edge select bit i at 1, a rising edge (polarity 1) or a falling edge (polarity 0) on an enabled source sets a sticky latch. The latch stays set after the input returns. It is cleared only by a 0x2C write with bit i set, and enabling the source again does not bring it back.
- R8: A read of offset 0x40 returns a word whose bit i is 1 exactly when source i is enabled and active (level mode) or latched (edge mode).
- R9: Output bit irq_out[c*4+p] is the OR of the pending bits of every source whose steering byte has core bit c (bits 3:0) and line bit 4+p (bits 7:4) both set. A byte with several bits set drives several outputs. The outputs are registered.
- R10: Reads of unmapped offsets return zero. Writes to unmapped offsets or to the read-only offsets 0x24 and 0x40 change no state.
- R11: A source whose enable bit is 0 drives no output and no pending bit, whatever its input does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe; the access completes in one cycle |
| bus_wdata | input | 32 | Write data (steering writes use bits 7:0) |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_in | input | 32 | Interrupt request inputs, asynchronous |
| irq_out | output | 16 | Parent lines, index core*4 + line |

## Verification
The assertions assume each write cycle presents one stable address with defined data. They also assume that a set write and a clear write never fall in the same cycle, because they share the single bus. The stimulus drives every bus and input change one nanosecond after a rising edge. It holds each input level for several cycles, so the synchronizer always sees a clean transition. Polarity and edge settings for a source are changed only while that source is disabled, so a change of setting never forms a false edge that the latch-clearing checks would have to account for.

// File: rtl/irq_rt_pkg.sv
package irq_rt_pkg;
   localparam logic [7:0] OFS_EN_STAT = 8'h24;
   localparam logic [7:0] OFS_EN_SET  = 8'h28;
   localparam logic [7:0] OFS_EN_CLR  = 8'h2C;
   localparam logic [7:0] OFS_POL     = 8'h30;
   localparam logic [7:0] OFS_EDGE    = 8'h34;
   localparam logic [7:0] OFS_PEND    = 8'h40;
   localparam int unsigned STEER_W    = 8;
endpackage

// File: rtl/irq_rt_regs.sv
module irq_rt_regs
   import irq_rt_pkg::*;
#(
   parameter int unsigned NUM_SRC = 32,
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned DATA_W  = 32
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [ADDR_W-1:0]                 bus_addr,
   input  logic                              bus_wr,
   input  logic [DATA_W-1:0]                 bus_wdata,
   output logic [DATA_W-1:0]                 bus_rdata,
   input  logic [NUM_SRC-1:0]                pend,
   output logic [NUM_SRC-1:0]                en,
   output logic [NUM_SRC-1:0]                pol,
   output logic [NUM_SRC-1:0]                edge_sel,
   output logic [NUM_SRC-1:0]                clr_bits,
   output logic [NUM_SRC-1:0][STEER_W-1:0]   steer
);
   generate
      if (NUM_SRC > 32 || NUM_SRC < 1) begin : g_bad_src
         $error("irq_rt_regs: NUM_SRC must be 1..32");
      end
      if (DATA_W < NUM_SRC || DATA_W < STEER_W) begin : g_bad_data
         $error("irq_rt_regs: DATA_W too narrow");
      end
      if (ADDR_W < 7) begin : g_bad_addr
         $error("irq_rt_regs: ADDR_W must reach offset 0x40");
      end
   endgenerate

   logic [NUM_SRC-1:0] en_q, pol_q, edge_q, set_bits;
   logic [NUM_SRC-1:0][STEER_W-1:0] steer_q;
   logic hit_set, hit_clr, hit_pol, hit_edge;

   assign hit_set  = bus_wr && (bus_addr == ADDR_W'(OFS_EN_SET));
   assign hit_clr  = bus_wr && (bus_addr == ADDR_W'(OFS_EN_CLR));
   assign hit_pol  = bus_wr && (bus_addr == ADDR_W'(OFS_POL));
   assign hit_edge = bus_wr && (bus_addr == ADDR_W'(OFS_EDGE));
   assign set_bits = hit_set ? bus_wdata[NUM_SRC-1:0] : '0;
   assign clr_bits = hit_clr ? bus_wdata[NUM_SRC-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         pol_q  <= '0;
         edge_q <= '0;
      end else begin
         en_q <= (en_q | set_bits) & ~clr_bits;
         if (hit_pol)  pol_q  <= bus_wdata[NUM_SRC-1:0];
         if (hit_edge) edge_q <= bus_wdata[NUM_SRC-1:0];
      end
   end

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_steer
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            steer_q[i] <= '0;
         else if (bus_wr && bus_addr == ADDR_W'(i))
            steer_q[i] <= bus_wdata[STEER_W-1:0];
      end
   end

   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (bus_addr == ADDR_W'(i))
            bus_rdata[STEER_W-1:0] = steer_q[i];
      end
      if (bus_addr == ADDR_W'(OFS_EN_STAT)) bus_rdata[NUM_SRC-1:0] = en_q;
      if (bus_addr == ADDR_W'(OFS_POL))     bus_rdata[NUM_SRC-1:0] = pol_q;
      if (bus_addr == ADDR_W'(OFS_EDGE))    bus_rdata[NUM_SRC-1:0] = edge_q;
      if (bus_addr == ADDR_W'(OFS_PEND))    bus_rdata[NUM_SRC-1:0] = pend;
   end

   assign en       = en_q;
   assign pol      = pol_q;
   assign edge_sel = edge_q;
   assign steer    = steer_q;

   assert_set_takes_R4: assert property (@(posedge clk) disable iff (!rst_n)
      hit_set |=> ((en_q & $past(bus_wdata[NUM_SRC-1:0])) == $past(bus_wdata[NUM_SRC-1:0])));
   assert_set_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
      hit_set |=> ((en_q & ~$past(bus_wdata[NUM_SRC-1:0])) == ($past(en_q) & ~$past(bus_wdata[NUM_SRC-1:0]))));
   assert_clr_takes_R5: assert property (@(posedge clk) disable iff (!rst_n)
      hit_clr |=> ((en_q & $past(bus_wdata[NUM_SRC-1:0])) == '0));
endmodule

// File: rtl/irq_rt_src.sv
module irq_rt_src #(
   parameter int unsigned NUM_SRC     = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_in,
   input  logic [NUM_SRC-1:0] pol,
   input  logic [NUM_SRC-1:0] edge_sel,
   input  logic [NUM_SRC-1:0] en,
   input  logic [NUM_SRC-1:0] clr_bits,
   output logic [NUM_SRC-1:0] pend
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("irq_rt_src: SYNC_STAGES must be at least 2");
      end
   endgenerate

   localparam int unsigned LAST = SYNC_STAGES - 1;

   logic [SYNC_STAGES-1:0][NUM_SRC-1:0] sync_q;
   logic [NUM_SRC-1:0] act, act_prev_q, hit, lat_q;

   for (genvar k = 0; k < SYNC_STAGES; k++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            sync_q[k] <= '0;
         else if (k == 0)
            sync_q[k] <= irq_in;
         else
            sync_q[k] <= sync_q[(k == 0) ? 0 : k-1];
      end
   end

   assign act = sync_q[LAST] ~^ pol;
   assign hit = act & ~act_prev_q & en & edge_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_prev_q <= '0;
         lat_q      <= '0;
      end else begin
         act_prev_q <= act;
         lat_q      <= (lat_q | hit) & ~clr_bits;
      end
   end

   assign pend = en & ((edge_sel & lat_q) | (~edge_sel & act));

   assert_latch_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_bits != '0) |=> ((lat_q & $past(clr_bits)) == '0));
   assert_latch_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_bits == '0) |=> ((lat_q & $past(lat_q)) == $past(lat_q)));
endmodule

// File: rtl/irq_rt_xbar.sv
module irq_rt_xbar
   import irq_rt_pkg::*;
#(
   parameter int unsigned NUM_SRC  = 32,
   parameter int unsigned NUM_CORE = 4,
   parameter int unsigned NUM_LINE = 4
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [NUM_SRC-1:0]              pend,
   input  logic [NUM_SRC-1:0][STEER_W-1:0] steer,
   output logic [NUM_CORE*NUM_LINE-1:0]    irq_out
);
   generate
      if (NUM_CORE + NUM_LINE != STEER_W) begin : g_bad_split
         $error("irq_rt_xbar: core and line masks must fill the steering byte");
      end
   endgenerate

   logic [NUM_CORE*NUM_LINE-1:0] out_q;

   for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
      for (genvar p = 0; p < NUM_LINE; p++) begin : g_line
         logic [NUM_SRC-1:0] sel;
         for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
            assign sel[i] = steer[i][c] & steer[i][NUM_CORE+p];
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) out_q[c*NUM_LINE+p] <= 1'b0;
            else        out_q[c*NUM_LINE+p] <= |(pend & sel);
         end
      end
   end

   assign irq_out = out_q;

   assert_quiet_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pend == '0) |=> (irq_out == '0));
   assert_unsteered_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (steer == '0) |=> (irq_out == '0));
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
   import irq_rt_pkg::*;
#(
   parameter int unsigned NUM_SRC     = 32,
   parameter int unsigned NUM_CORE    = 4,
   parameter int unsigned NUM_LINE    = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 32
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [ADDR_W-1:0]            bus_addr,
   input  logic                         bus_wr,
   input  logic [DATA_W-1:0]            bus_wdata,
   output logic [DATA_W-1:0]            bus_rdata,
   input  logic [NUM_SRC-1:0]           irq_in,
   output logic [NUM_CORE*NUM_LINE-1:0] irq_out
);
   logic [NUM_SRC-1:0] en, pol, edge_sel, clr_bits, pend;
   logic [NUM_SRC-1:0][STEER_W-1:0] steer;

   irq_rt_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pend(pend), .en(en),
      .pol(pol), .edge_sel(edge_sel), .clr_bits(clr_bits), .steer(steer)
   );

   irq_rt_src #(.NUM_SRC(NUM_SRC), .SYNC_STAGES(SYNC_STAGES)) src_i (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .pol(pol), .edge_sel(edge_sel),
      .en(en), .clr_bits(clr_bits), .pend(pend)
   );

   irq_rt_xbar #(.NUM_SRC(NUM_SRC), .NUM_CORE(NUM_CORE), .NUM_LINE(NUM_LINE)) xbar_i (
      .clk(clk), .rst_n(rst_n), .pend(pend), .steer(steer), .irq_out(irq_out)
   );

   assert_disabled_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (en == '0) |=> (irq_out == '0));
   assert_pend_needs_enable_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend & ~en) == '0));
endmodule

// File: tb/irq_route_ctrl_tb_top.sv
module irq_route_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] irq_v = '0;
   logic [15:0] irq_out;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   typedef struct {
      bit          is_rd;
      logic [31:0] exp;
      string       tag;
   } sb_item_t;
   sb_item_t sb_q[$];

   always #2 clk = ~clk;

   irq_route_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_v), .irq_out(irq_out)
   );

   // monitor: pops one expected item per falling edge and compares
   always @(negedge clk) begin
      if (sb_q.size() > 0) begin
         sb_item_t it;
         logic [31:0] act;
         it  = sb_q.pop_front();
         act = it.is_rd ? bus_rdata : {16'h0, irq_out};
         n_tests++;
         if (act !== it.exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
         end
      end
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic rd_chk(input logic [7:0] a, input logic [31:0] e, input string tag);
      @(posedge clk); #1;
      bus_addr = a;
      sb_q.push_back('{is_rd: 1'b1, exp: e, tag: tag});
      @(negedge clk); #1;
   endtask

   task automatic out_chk(input logic [15:0] e, input string tag);
      @(posedge clk); #1;
      sb_q.push_back('{is_rd: 1'b0, exp: {16'h0, e}, tag: tag});
      @(negedge clk); #1;
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic set_src(input int i, input logic v);
      @(posedge clk); #1;
      irq_v[i] = v;
   endtask

   initial begin
      #200000;
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] pol_v, edge_v;
      pol_v = '0; edge_v = '0;
      wait_cyc(3);
      rst_n = 1'b1;
      wait_cyc(2);

      // R1 reset state
      rd_chk(8'h24, 32'h0, "R1 enable mask");
      rd_chk(8'h30, 32'h0, "R1 polarity");
      rd_chk(8'h34, 32'h0, "R1 edge select");
      rd_chk(8'h40, 32'h0, "R1 pending");
      rd_chk(8'h05, 32'h0, "R1 steering byte");
      out_chk(16'h0, "R1 outputs");

      // R2 steering bytes
      wr(8'h03, 32'h21);
      rd_chk(8'h03, 32'h21, "R2 byte 3");
      wr(8'h1F, 32'hFFFF_FF12);
      rd_chk(8'h1F, 32'h12, "R2 byte 31 zero-extended");

      // R3 R4 R5 enable handling
      wr(8'h28, 32'h9);
      rd_chk(8'h24, 32'h9, "R3 R4 set");
      wr(8'h28, 32'h10);
      rd_chk(8'h24, 32'h19, "R4 zeros keep");
      wr(8'h2C, 32'h1);
      rd_chk(8'h24, 32'h18, "R5 clear one");
      wr(8'h2C, 32'hFFFF_FFFF);
      rd_chk(8'h24, 32'h0, "R5 clear all");

      // R6 level active-high, source 3 -> core0 line1 (bit 1)
      pol_v[3] = 1'b1;
      wr(8'h30, pol_v);
      wr(8'h28, 32'h8);
      set_src(3, 1'b1);
      wait_cyc(4);
      out_chk(16'h0002, "R6 R9 level high asserted");
      rd_chk(8'h40, 32'h8, "R8 pending level");
      set_src(3, 1'b0);
      wait_cyc(4);
      out_chk(16'h0000, "R6 level follows input");

      // R6 level active-low, source 7 -> core2 line3 (bit 11)
      set_src(7, 1'b0);
      wr(8'h07, 32'h84);
      wr(8'h28, 32'h80);
      wait_cyc(4);
      out_chk(16'h0800, "R6 active low asserted");
      set_src(7, 1'b1);
      wait_cyc(4);
      out_chk(16'h0000, "R6 active low released");
      wr(8'h2C, 32'h80);

      // R7 rising edge, source 12 -> cores 0,1 line0 (bits 0 and 4)
      pol_v[12] = 1'b1; edge_v[12] = 1'b1;
      wr(8'h30, pol_v);
      wr(8'h34, edge_v);
      wr(8'h0C, 32'h13);
      wr(8'h28, 32'h1000);
      wait_cyc(4);
      out_chk(16'h0000, "R7 no edge yet");
      set_src(12, 1'b1);
      wait_cyc(3);
      set_src(12, 1'b0);
      wait_cyc(4);
      out_chk(16'h0011, "R7 R9 sticky rising fan-out");
      rd_chk(8'h40, 32'h1000, "R8 pending edge");
      wr(8'h2C, 32'h1000);
      wait_cyc(3);
      out_chk(16'h0000, "R7 cleared by disable");
      wr(8'h28, 32'h1000);
      wait_cyc(3);
      out_chk(16'h0000, "R7 stays clear on re-enable");
      wr(8'h2C, 32'h1000);

      // R7 falling edge, source 20 -> core3 line2 (bit 14)
      set_src(20, 1'b1);
      edge_v[20] = 1'b1;
      wr(8'h34, edge_v);
      wr(8'h14, 32'h48);
      wait_cyc(3);
      wr(8'h28, 32'h0010_0000);
      wait_cyc(4);
      out_chk(16'h0000, "R7 falling not yet");
      set_src(20, 1'b0);
      wait_cyc(4);
      out_chk(16'h4000, "R7 falling latched");
      set_src(20, 1'b1);
      wait_cyc(4);
      out_chk(16'h4000, "R7 falling sticky");
      wr(8'h2C, 32'h0010_0000);
      wait_cyc(3);
      out_chk(16'h0000, "R7 falling cleared");

      // R11 disabled source, source 25 -> core0 line0 (bit 0)
      pol_v[25] = 1'b1;
      wr(8'h30, pol_v);
      wr(8'h19, 32'h11);
      set_src(25, 1'b1);
      wait_cyc(4);
      out_chk(16'h0000, "R11 disabled no output");
      rd_chk(8'h40, 32'h0, "R11 disabled no pending");
      rd_chk(8'h24, 32'h8, "R3 mask after sequence");

      // R9 OR of two sources on one line
      wr(8'h03, 32'h11);
      wr(8'h28, 32'h0200_0000);
      wait_cyc(3);
      out_chk(16'h0001, "R9 first source");
      set_src(3, 1'b1);
      wait_cyc(4);
      out_chk(16'h0001, "R9 two sources");
      rd_chk(8'h40, 32'h0200_0008, "R8 two pending");
      wr(8'h2C, 32'h0200_0000);
      wait_cyc(3);
      out_chk(16'h0001, "R9 remaining source holds line");
      set_src(3, 1'b0);
      wait_cyc(4);
      out_chk(16'h0000, "R9 line drops");

      // R10 unmapped and read-only offsets
      rd_chk(8'h20, 32'h0, "R10 read 0x20");
      rd_chk(8'h3C, 32'h0, "R10 read 0x3C");
      rd_chk(8'h80, 32'h0, "R10 read 0x80");
      wr(8'h40, 32'hFFFF_FFFF);
      wr(8'h24, 32'hFFFF_FFFF);
      wr(8'h20, 32'hFF);
      wr(8'h38, 32'hFFFF_FFFF);
      rd_chk(8'h24, 32'h8, "R10 enable untouched");
      rd_chk(8'h00, 32'h0, "R10 byte 0 untouched");
      rd_chk(8'h30, pol_v, "R10 polarity untouched");
      rd_chk(8'h34, edge_v, "R10 edge untouched");
      wait_cyc(3);
      out_chk(16'h0000, "R10 outputs untouched");

      wait_cyc(2);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule